// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block carries out the hardware side of taking an exception on a small 32-bit processor. When the core accepts an exception, it raises a one-cycle request with the exception number, its current register values, the current mode, and the control bit that picks the thread stack. The sequencer keeps the two banked stack pointers itself: main and process. It takes the active pointer down by the size of an eight-word frame and writes that frame, one word per handshake beat, through a memory write port.

After the last frame word is written, it reads the handler address from a vector table whose base can be moved. It then produces the new program counter, the exception-return code for the link register, and handler mode. It signals completion with a one-cycle pulse. The core loads each stack pointer through a small write port. The pointers are always visible on the outputs.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, both stack pointers read 0, the table base is 0, `out_handler` is 0, and `busy`, `done`, `mw_valid` and `mr_valid` are all 0.
- R2: A stack pointer write (`sp_wr_sel` 0 = main, 1 = process) stores the data with bits 1:0 forced to zero, so both pointers always read word aligned.
- R3: The stack used for the frame is the main pointer when `in_handler` is 1, whatever `ctrl_psp` says. In thread mode (`in_handler` 0), `ctrl_psp` 1 selects the process pointer and 0 selects the main pointer.
- R4: On a request, the selected pointer is reduced by 32 (modulo 2^32). The frame is written as eight beats at addresses new_sp + 4*i for i = 0..7, in the order R0, R1, R2, R3, R12, LR, PC, status word. Address and data stay stable while `mw_valid` is high and `mw_ready` is low.
- R5: The register values, exception number, mode and control bit are captured in the request cycle. Later changes to those inputs do not affect the frame, the vector address or the return code.
- R6: The vector read starts only after all eight frame beats have completed. It reads address base + 4*exception_number. A base write stores the data with bits 1:0 forced to zero.
- R7: `new_pc` is the word returned by the vector read with bit 0 cleared.
- R8: `new_lr` is 0xFFFFFFF1 if the exception was taken from handler mode, 0xFFFFFFF9 if taken from thread mode on the main stack, and 0xFFFFFFFD if taken from thread mode on the process stack.
- R9: `done` pulses for one cycle once `new_pc`, `new_lr` and `out_handler` (set to 1) hold their new values. This happens no sooner than 10 cycles after the request, and `busy` is 0 in the following cycle.
- R10: While `busy` is 1, stack pointer writes, base writes and new requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Accepted-exception request, one cycle |
| exc_num | input | NUM_W | Exception number |
| in_handler | input | 1 | Core is in handler mode |
| ctrl_psp | input | 1 | Thread mode uses the process stack |
| r0 | input | W | Register R0 value |
| r1 | input | W | Register R1 value |
| r2 | input | W | Register R2 value |
| r3 | input | W | Register R3 value |
| r12 | input | W | Register R12 value |
| lr_val | input | W | Link register value |
| pc_val | input | W | Return program counter |
| psr_val | input | W | Status word |
| sp_wr_en | input | 1 | Stack pointer write strobe |
| sp_wr_sel | input | 1 | 0 main, 1 process |
| sp_wr_data | input | W | Stack pointer write data |
| vtor_wr_en | input | 1 | Vector table base write strobe |
| vtor_wr_data | input | W | Vector table base write data |
| mw_valid | output | 1 | Frame write beat valid |
| mw_ready | input | 1 | Memory accepts the beat |
| mw_addr | output | W | Frame write address |
| mw_data | output | W | Frame write data |
| mr_valid | output | 1 | Vector read request |
| mr_ready | input | 1 | Read data valid on `mr_data` |
| mr_addr | output | W | Vector address |
| mr_data | input | W | Vector word |
| msp | output | W | Main stack pointer |
| psp | output | W | Process stack pointer |
| new_pc | output | W | Handler entry address |
| new_lr | output | W | Exception-return code |
| out_handler | output | 1 | Mode after entry, 1 = handler |
| busy | output | 1 | Entry in progress |
| done | output | 1 | Entry complete, one cycle |

## Verification
The hardest cases to reach are those where the memory stalls partway through the frame while the core's inputs are already changing. Stray pointer writes, base writes and requests arriving in the middle of a sequence are also hard to provoke. The stimulus randomises both ready signals on every cycle so beats stall at random points. In the cycle after each request it scrambles every register input, the exception number and the mode. In some runs it also fires pointer writes, base writes and a new request while the sequencer is busy. Directed runs cover each return code, a pointer that wraps below zero, the highest exception number, and a relocated table base.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int FRAME_WORDS = 8;
  localparam int FRAME_BYTES = 4 * FRAME_WORDS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALLOC,
    ST_PUSH,
    ST_VEC,
    ST_DONE
  } seq_state_t;

  localparam logic [31:0] RET_FROM_HANDLER = 32'hFFFF_FFF1;
  localparam logic [31:0] RET_THREAD_MAIN  = 32'hFFFF_FFF9;
  localparam logic [31:0] RET_THREAD_PROC  = 32'hFFFF_FFFD;
endpackage

// File: rtl/exc_sp_bank.sv
module exc_sp_bank #(
  parameter int W           = 32,
  parameter int FRAME_BYTES = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         alloc_en,
  input  logic         alloc_sel,
  output logic [W-1:0] msp,
  output logic [W-1:0] psp
);
  localparam logic [W-1:0] ALIGN_MASK = ~W'(3);
  localparam logic [W-1:0] FB         = W'(FRAME_BYTES);

  logic [W-1:0] msp_q, msp_d, psp_q, psp_d;

  always_comb begin
    msp_d = msp_q;
    psp_d = psp_q;
    if (alloc_en) begin
      if (alloc_sel) psp_d = psp_q - FB;
      else           msp_d = msp_q - FB;
    end else if (wr_en) begin
      if (wr_sel) psp_d = wr_data & ALIGN_MASK;
      else        msp_d = wr_data & ALIGN_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msp_q <= '0;
      psp_q <= '0;
    end else begin
      msp_q <= msp_d;
      psp_q <= psp_d;
    end
  end

  assign msp = msp_q;
  assign psp = psp_q;

  // R2: both pointers stay word aligned
  a_r2_sp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (msp[1:0] == 2'b00) && (psp[1:0] == 2'b00));

  // R4: frame allocation lowers the chosen pointer by the frame size
  a_r4_alloc_main: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !alloc_sel) |=> (msp == $past(msp) - FB) && $stable(psp));

  a_r4_alloc_proc: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && alloc_sel) |=> (psp == $past(psp) - FB) && $stable(msp));
endmodule

// File: rtl/exc_frame_store.sv
module exc_frame_store #(
  parameter int W = 32,
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [N-1:0][W-1:0] in_words,
  input  logic [IDX_W-1:0]    sel,
  output logic [W-1:0]        word_out
);
  logic [N-1:0][W-1:0] slots;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= in_words[g];
    end
    assign slots[g] = q;
  end

  assign word_out = slots[sel];
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int W     = 32,
  parameter int NUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [NUM_W-1:0] exc_num,
  input  logic             in_handler,
  input  logic             ctrl_psp,
  input  logic [W-1:0]     r0,
  input  logic [W-1:0]     r1,
  input  logic [W-1:0]     r2,
  input  logic [W-1:0]     r3,
  input  logic [W-1:0]     r12,
  input  logic [W-1:0]     lr_val,
  input  logic [W-1:0]     pc_val,
  input  logic [W-1:0]     psr_val,
  input  logic             sp_wr_en,
  input  logic             sp_wr_sel,
  input  logic [W-1:0]     sp_wr_data,
  input  logic             vtor_wr_en,
  input  logic [W-1:0]     vtor_wr_data,
  output logic             mw_valid,
  input  logic             mw_ready,
  output logic [W-1:0]     mw_addr,
  output logic [W-1:0]     mw_data,
  output logic             mr_valid,
  input  logic             mr_ready,
  output logic [W-1:0]     mr_addr,
  input  logic [W-1:0]     mr_data,
  output logic [W-1:0]     msp,
  output logic [W-1:0]     psp,
  output logic [W-1:0]     new_pc,
  output logic [W-1:0]     new_lr,
  output logic             out_handler,
  output logic             busy,
  output logic             done
);
  localparam int           IDX_W      = $clog2(FRAME_WORDS);
  localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(FRAME_WORDS - 1);
  localparam logic [W-1:0] FB         = W'(FRAME_BYTES);
  localparam logic [W-1:0] ALIGN_MASK = ~W'(3);
  localparam logic [W-1:0] PC_MASK    = ~W'(1);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] beat_q, beat_d;
  logic [NUM_W-1:0] num_q, num_d;
  logic             use_psp_q, use_psp_d;
  logic             from_hnd_q, from_hnd_d;
  logic [W-1:0]     base_q, base_d;
  logic [W-1:0]     vtor_q, vtor_d;
  logic [W-1:0]     pc_q, pc_d, lr_q, lr_d;
  logic             hnd_q, hnd_d;
  logic             load, alloc_en, sp_wr_ok;
  logic             sel_psp_now;
  logic [FRAME_WORDS-1:0][W-1:0] frame_in;

  assign busy        = (state_q != ST_IDLE);
  assign sel_psp_now = !in_handler && ctrl_psp;
  assign sp_wr_ok    = sp_wr_en && !busy;
  assign frame_in    = {psr_val, pc_val, lr_val, r12, r3, r2, r1, r0};

  exc_sp_bank #(.W(W), .FRAME_BYTES(FRAME_BYTES)) u_sp_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sp_wr_ok), .wr_sel(sp_wr_sel), .wr_data(sp_wr_data),
    .alloc_en(alloc_en), .alloc_sel(use_psp_q),
    .msp(msp), .psp(psp)
  );

  exc_frame_store #(.W(W), .N(FRAME_WORDS)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_words(frame_in), .sel(beat_q), .word_out(mw_data)
  );

  always_comb begin
    state_d    = state_q;
    beat_d     = beat_q;
    num_d      = num_q;
    use_psp_d  = use_psp_q;
    from_hnd_d = from_hnd_q;
    base_d     = base_q;
    vtor_d     = vtor_q;
    pc_d       = pc_q;
    lr_d       = lr_q;
    hnd_d      = hnd_q;
    load       = 1'b0;
    alloc_en   = 1'b0;
    mw_valid   = 1'b0;
    mr_valid   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (vtor_wr_en) vtor_d = vtor_wr_data & ALIGN_MASK;
        if (req) begin
          load       = 1'b1;
          num_d      = exc_num;
          use_psp_d  = sel_psp_now;
          from_hnd_d = in_handler;
          base_d     = (sel_psp_now ? psp : msp) - FB;
          state_d    = ST_ALLOC;
        end
      end
      ST_ALLOC: begin
        alloc_en = 1'b1;
        beat_d   = '0;
        state_d  = ST_PUSH;
      end
      ST_PUSH: begin
        mw_valid = 1'b1;
        if (mw_ready) begin
          if (beat_q == LAST_BEAT) state_d = ST_VEC;
          else                     beat_d  = beat_q + 1'b1;
        end
      end
      ST_VEC: begin
        mr_valid = 1'b1;
        if (mr_ready) begin
          pc_d    = mr_data & PC_MASK;
          lr_d    = from_hnd_q ? W'(RET_FROM_HANDLER)
                  : (use_psp_q ? W'(RET_THREAD_PROC) : W'(RET_THREAD_MAIN));
          hnd_d   = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      beat_q     <= '0;
      num_q      <= '0;
      use_psp_q  <= 1'b0;
      from_hnd_q <= 1'b0;
      base_q     <= '0;
      vtor_q     <= '0;
      pc_q       <= '0;
      lr_q       <= '0;
      hnd_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      beat_q     <= beat_d;
      num_q      <= num_d;
      use_psp_q  <= use_psp_d;
      from_hnd_q <= from_hnd_d;
      base_q     <= base_d;
      vtor_q     <= vtor_d;
      pc_q       <= pc_d;
      lr_q       <= lr_d;
      hnd_q      <= hnd_d;
    end
  end

  assign mw_addr     = base_q + {{(W-IDX_W-2){1'b0}}, beat_q, 2'b00};
  assign mr_addr     = vtor_q + {{(W-NUM_W-2){1'b0}}, num_q, 2'b00};
  assign new_pc      = pc_q;
  assign new_lr      = lr_q;
  assign out_handler = hnd_q;
  assign done        = (state_q == ST_DONE);

  // R4: a stalled frame beat holds address and data
  a_r4_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  // R6: frame writes and the vector read never overlap
  a_r6_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mw_valid, mr_valid}));

  // R7: the handler address is always even
  a_r7_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !new_pc[0]);

  // R8: the link value is one of the return codes
  a_r8_lr_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_lr[W-1:4] == '1) && (new_lr[0] == 1'b1));

  // R9: completion comes with handler mode and is a single pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_handler ##1 (!done && !busy));

  // R10: pointers do not move while waiting for the memory
  a_r10_busy_sp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid || mr_valid) |=> $stable(msp) && $stable(psp));
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam int W     = 32;
  localparam int NUM_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req, in_handler, ctrl_psp;
  logic [NUM_W-1:0] exc_num;
  logic [W-1:0]     r0, r1, r2, r3, r12, lr_val, pc_val, psr_val;
  logic             sp_wr_en, sp_wr_sel, vtor_wr_en;
  logic [W-1:0]     sp_wr_data, vtor_wr_data;
  logic             mw_valid, mw_ready, mr_valid, mr_ready;
  logic [W-1:0]     mw_addr, mw_data, mr_addr, mr_data;
  logic [W-1:0]     msp, psp, new_pc, new_lr;
  logic             out_handler, busy, done;

  int n_checks = 0;
  int n_errors = 0;
  logic [W-1:0] msp_m, psp_m, vtor_m;

  always #10 clk = ~clk;

  function automatic logic [W-1:0] vec_word(input logic [W-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F ^ {a[3:0], 28'h0};
  endfunction

  assign mr_data = vec_word(mr_addr);

  exc_entry_seq #(.W(W), .NUM_W(NUM_W)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .exc_num(exc_num),
    .in_handler(in_handler), .ctrl_psp(ctrl_psp),
    .r0(r0), .r1(r1), .r2(r2), .r3(r3), .r12(r12),
    .lr_val(lr_val), .pc_val(pc_val), .psr_val(psr_val),
    .sp_wr_en(sp_wr_en), .sp_wr_sel(sp_wr_sel), .sp_wr_data(sp_wr_data),
    .vtor_wr_en(vtor_wr_en), .vtor_wr_data(vtor_wr_data),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_addr(mr_addr), .mr_data(mr_data),
    .msp(msp), .psp(psp), .new_pc(new_pc), .new_lr(new_lr),
    .out_handler(out_handler), .busy(busy), .done(done)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_lr(input logic hnd, input logic use_p);
    if (hnd) return 32'hFFFF_FFF1;
    return use_p ? 32'hFFFF_FFFD : 32'hFFFF_FFF9;
  endfunction

  task automatic write_sp(input logic sel, input logic [W-1:0] d);
    @(negedge clk);
    sp_wr_en = 1'b1; sp_wr_sel = sel; sp_wr_data = d;
    @(negedge clk);
    sp_wr_en = 1'b0;
    if (sel) psp_m = d & ~32'd3; else msp_m = d & ~32'd3;
  endtask

  task automatic write_vtor(input logic [W-1:0] d);
    @(negedge clk);
    vtor_wr_en = 1'b1; vtor_wr_data = d;
    @(negedge clk);
    vtor_wr_en = 1'b0;
    vtor_m = d & ~32'd3;
  endtask

  task automatic run_entry(input logic hnd, input logic ctl, input logic [NUM_W-1:0] num,
                           input logic perturb);
    logic [W-1:0] fr [8];
    logic         use_p;
    logic [W-1:0] base, vaddr;
    int           cycles, beats;
    logic         got;
    for (int i = 0; i < 8; i++) fr[i] = $urandom;
    @(negedge clk);
    in_handler = hnd; ctrl_psp = ctl; exc_num = num;
    r0 = fr[0]; r1 = fr[1]; r2 = fr[2]; r3 = fr[3];
    r12 = fr[4]; lr_val = fr[5]; pc_val = fr[6]; psr_val = fr[7];
    req = 1'b1;
    use_p = !hnd && ctl;
    base  = (use_p ? psp_m : msp_m) - 32'd32;
    vaddr = vtor_m + {22'd0, num, 2'b00};
    cycles = 0; beats = 0; got = 1'b0;
    while (!got && cycles < 400) begin
      @(negedge clk);
      cycles++;
      req = (perturb && cycles == 3);
      if (cycles == 1) begin
        // R5: scramble all captured inputs after the request
        r0 = $urandom; r1 = $urandom; r2 = $urandom; r3 = $urandom;
        r12 = $urandom; lr_val = $urandom; pc_val = $urandom; psr_val = $urandom;
        exc_num = NUM_W'($urandom); in_handler = ~hnd; ctrl_psp = ~ctl;
      end
      sp_wr_en   = perturb && cycles == 3;
      sp_wr_sel  = $urandom % 2;
      sp_wr_data = $urandom;
      vtor_wr_en = perturb && cycles == 4;
      vtor_wr_data = $urandom;
      mw_ready = ($urandom % 4) != 0;
      mr_ready = ($urandom % 3) != 0;
      #1;
      if (mw_valid && mw_ready) begin
        if (beats < 8) begin
          check("R4 frame addr", mw_addr, base + 32'(beats * 4));
          check("R5 frame data", mw_data, fr[beats]);
        end
        beats++;
      end
      if (mr_valid && mr_ready) begin
        check("R6 read after frame", 32'(beats), 32'd8);
        check("R6 vector addr", mr_addr, vaddr);
      end
      if (done) got = 1'b1;
    end
    req = 1'b0; sp_wr_en = 1'b0; vtor_wr_en = 1'b0;
    if (!got) begin
      n_checks++; n_errors++;
      $display("FAIL R9 watchdog actual=no_done expected=done");
      return;
    end
    if (use_p) psp_m = base; else msp_m = base;
    check("R9 latency>=10", 32'(cycles >= 10), 32'd1);
    check("R7 new_pc", new_pc, vec_word(vaddr) & ~32'd1);
    check("R8 new_lr", new_lr, exp_lr(hnd, use_p));
    check("R9 mode", {31'd0, out_handler}, 32'd1);
    check("R3/R10 msp", msp, msp_m);
    check("R3/R10 psp", psp, psp_m);
    @(negedge clk);
    #1;
    check("R9 done pulse", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req = 1'b0; in_handler = 1'b0; ctrl_psp = 1'b0; exc_num = '0;
    r0 = '0; r1 = '0; r2 = '0; r3 = '0; r12 = '0; lr_val = '0; pc_val = '0; psr_val = '0;
    sp_wr_en = 1'b0; sp_wr_sel = 1'b0; sp_wr_data = '0;
    vtor_wr_en = 1'b0; vtor_wr_data = '0; mw_ready = 1'b0; mr_ready = 1'b0;
    msp_m = '0; psp_m = '0; vtor_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 msp reset", msp, 32'd0);
    check("R1 psp reset", psp, 32'd0);
    check("R1 flags reset", {27'd0, busy, done, mw_valid, mr_valid, out_handler}, 32'd0);

    // R6: first entry relies on the table base resetting to 0
    run_entry(1'b0, 1'b0, 8'd3, 1'b0);

    write_sp(1'b0, 32'h2000_1003);
    #1 check("R2 msp align", msp, 32'h2000_1000);
    write_sp(1'b1, 32'h2000_0807);
    #1 check("R2 psp align", psp, 32'h2000_0804);

    run_entry(1'b0, 1'b0, 8'd3, 1'b0);   // R8 thread main
    run_entry(1'b0, 1'b1, 8'd15, 1'b1);  // R8 thread process, R10 busy writes
    run_entry(1'b1, 1'b1, 8'd11, 1'b0);  // R3 handler ignores ctrl_psp

    write_vtor(32'h0000_8043);           // R6 relocated, low bits dropped
    run_entry(1'b0, 1'b1, 8'd255, 1'b0);

    write_sp(1'b0, 32'h0000_0010);       // R4 wrap below zero
    run_entry(1'b1, 1'b0, 8'd16, 1'b1);

    for (int t = 0; t < 40; t++) begin
      if ($urandom % 3 == 0) write_sp($urandom % 2, $urandom);
      if ($urandom % 5 == 0) write_vtor($urandom);
      run_entry($urandom % 2, $urandom % 2, NUM_W'($urandom), ($urandom % 2) == 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule